// File: doc/BRIEF.md
# Trap Vector Dispatcher

This block sits in a processor's trap unit. When a trap is raised, it is given the current trap level, the three mode bits (red, hpriv, priv), the pending trap type and the two trap table base registers. From these it picks the handling path and computes the handler fetch address and the address that follows it. There are four handling paths: error recovery, guest watchdog, hyperprivileged and privileged. There is one more outcome: when the trap level is already saturated, the block reports an error-state condition and produces no vector.

A request is a single-cycle strobe, and the block decides in combinational logic. One clock edge later the registered result appears with a one-cycle valid pulse. The result stays unchanged until the next request. Saving the trap stack and fetching from the handler are left to other blocks.

Top module: `trap_dispatch`

## Requirements
- R1: A request captured at a clock edge gives `outValid` high for exactly the following cycle. Without a request, all result outputs keep their values.
- R2: The current privilege is hyperprivileged when `hprivBit` is 1, otherwise privileged when `privBit` is 1, otherwise user. The target is hyperprivileged only when the current privilege is hyperprivileged; user and privileged traps target privileged.
- R3: When `redBit` is 1, or the trap level equals MAX_TL-1, the path code is 1 (recovery). The effective type is 5 and the PC is 0xFFF0000000 ORed with ((5<<5) & 0xFF), which is 0xFFF00000A0. This takes priority over every other rule.
- R4: When `redBit` is 0 and the trap level is MAX_TL or above, the path code is 5 (error) and `errorState` is 1. PC and NPC are 0 and the effective type equals the input type. On every other path `errorState` is 0.
- R5: When the level exceeds MAX_PTL and the target is privileged, the path code is 2 (watchdog). The effective type is 2 and the PC is the hyper vector built from type 2.
- R6: Otherwise, the path code is 3 (hyper) when the target is hyperprivileged or the type is 384 or above. Type 383 with a privileged target gives path code 4 (privileged). The effective type on both paths is the input type.
- R7: The hyper vector is `hyperBase` with bits 13:0 cleared, ORed with (type<<5) kept to bits 13:0.
- R8: The privileged vector is `privBase` with bits 14:0 cleared, ORed with (type<<5) kept to bits 13:0. Bit 14 is also set when the new trap level (current level plus one) exceeds 1.
- R9: On the recovery, watchdog, hyper and privileged paths, NPC equals PC plus 4.
- R10: After reset, `outValid`, `errorState`, the path code (0, idle), the type, PC and NPC are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle dispatch request |
| trapLevel | input | TL_W | Trap level before the trap |
| redBit | input | 1 | Error-recovery mode bit |
| hprivBit | input | 1 | Hyperprivileged mode bit |
| privBit | input | 1 | Privileged mode bit |
| trapType | input | TYPE_W | Pending trap type |
| hyperBase | input | ADDR_W | Hyper trap table base |
| privBase | input | ADDR_W | Privileged trap table base |
| outValid | output | 1 | Result valid pulse |
| errorState | output | 1 | Trap level saturated, no vector |
| pathCode | output | 3 | 0 idle, 1 recovery, 2 watchdog, 3 hyper, 4 privileged, 5 error |
| handlerType | output | TYPE_W | Effective trap type for the handler |
| handlerPc | output | ADDR_W | Handler PC |
| handlerNpc | output | ADDR_W | Handler NPC |

## Verification
Several rules overlap on a single request. The red bit can be set while the level is saturated or above the privileged maximum. A high trap type can arrive while the level calls for the watchdog. The bench provokes these overlaps with random levels, mode bits and types, and judges each outcome against a reference function that applies the priority order. It also adds directed requests at level MAX_TL-1, at MAX_TL with and without red, and with type 383 against 384.

// File: rtl/trap_disp_pkg.sv
package trap_disp_pkg;
  typedef enum logic [2:0] {
    PATH_IDLE     = 3'd0,
    PATH_RECOVER  = 3'd1,
    PATH_WATCHDOG = 3'd2,
    PATH_HYPER    = 3'd3,
    PATH_PRIV     = 3'd4,
    PATH_ERROR    = 3'd5
  } pathSel_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_PRIV  = 2'd1,
    LVL_HYPER = 2'd2
  } privLvl_e;

  typedef struct packed {
    logic load;
    logic selRecover;
    logic selWatchdog;
    logic selHyper;
    logic selPriv;
    logic selError;
    logic tlAboveZero;
  } dispCtrl_t;
endpackage

// File: rtl/trap_disp_ctrl.sv
module trap_disp_ctrl
  import trap_disp_pkg::*;
#(
  parameter int MAX_TL         = 6,
  parameter int MAX_PTL        = 2,
  parameter int TL_W           = 3,
  parameter int TYPE_W         = 9,
  parameter int HYPER_TYPE_MIN = 384
) (
  input  logic              reqValid,
  input  logic [TL_W-1:0]   trapLevel,
  input  logic              redBit,
  input  logic              hprivBit,
  input  logic              privBit,
  input  logic [TYPE_W-1:0] trapType,
  output dispCtrl_t         ctrl
);
  localparam int RECOVER_TL = MAX_TL - 1;

  privLvl_e curLvl;
  privLvl_e targetLvl;
  logic     atRecoverLvl;
  logic     atErrorLvl;
  logic     aboveGuestMax;
  logic     highType;

  always_comb begin
    if (hprivBit)     curLvl = LVL_HYPER;
    else if (privBit) curLvl = LVL_PRIV;
    else              curLvl = LVL_USER;
    targetLvl = (curLvl == LVL_HYPER) ? LVL_HYPER : LVL_PRIV;
  end

  assign atRecoverLvl  = (int'(trapLevel) == RECOVER_TL);
  assign atErrorLvl    = (int'(trapLevel) >= MAX_TL);
  assign aboveGuestMax = (int'(trapLevel) > MAX_PTL);
  assign highType      = (int'(trapType) >= HYPER_TYPE_MIN);

  always_comb begin
    ctrl             = '0;
    ctrl.load        = reqValid;
    ctrl.tlAboveZero = (trapLevel != '0);
    if (redBit || atRecoverLvl)                         ctrl.selRecover  = 1'b1;
    else if (atErrorLvl)                                ctrl.selError    = 1'b1;
    else if (aboveGuestMax && targetLvl == LVL_PRIV)    ctrl.selWatchdog = 1'b1;
    else if (targetLvl == LVL_HYPER || highType)        ctrl.selHyper    = 1'b1;
    else                                                ctrl.selPriv     = 1'b1;
  end
endmodule

// File: rtl/trap_disp_datapath.sv
module trap_disp_datapath
  import trap_disp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int TYPE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dispCtrl_t         ctrl,
  input  logic [TYPE_W-1:0] trapType,
  input  logic [ADDR_W-1:0] hyperBase,
  input  logic [ADDR_W-1:0] privBase,
  output logic              outValid,
  output logic              errorState,
  output logic [2:0]        pathCode,
  output logic [TYPE_W-1:0] handlerType,
  output logic [ADDR_W-1:0] handlerPc,
  output logic [ADDR_W-1:0] handlerNpc
);
  localparam logic [ADDR_W-1:0] RECOVER_BASE = ADDR_W'(40'hFFF0000000);
  localparam logic [ADDR_W-1:0] MASK8        = ADDR_W'(8'hFF);
  localparam logic [ADDR_W-1:0] MASK14       = ADDR_W'(14'h3FFF);
  localparam logic [ADDR_W-1:0] MASK15       = ADDR_W'(15'h7FFF);
  localparam logic [ADDR_W-1:0] BIT14        = ADDR_W'(15'h4000);
  localparam logic [ADDR_W-1:0] INSN_BYTES   = ADDR_W'(4);

  logic [TYPE_W-1:0] effType;
  logic [ADDR_W-1:0] typeShift;
  logic [ADDR_W-1:0] nextPc;
  pathSel_e          nextPath;

  always_comb begin
    if (ctrl.selRecover)       effType = TYPE_W'(5);
    else if (ctrl.selWatchdog) effType = TYPE_W'(2);
    else                       effType = trapType;
    typeShift = ADDR_W'(effType) << 5;
  end

  always_comb begin
    nextPc   = '0;
    nextPath = PATH_PRIV;
    if (ctrl.selRecover) begin
      nextPath = PATH_RECOVER;
      nextPc   = RECOVER_BASE | (typeShift & MASK8);
    end else if (ctrl.selError) begin
      nextPath = PATH_ERROR;
      nextPc   = '0;
    end else if (ctrl.selWatchdog || ctrl.selHyper) begin
      nextPath = ctrl.selWatchdog ? PATH_WATCHDOG : PATH_HYPER;
      nextPc   = (hyperBase & ~MASK14) | (typeShift & MASK14);
    end else begin
      nextPath = PATH_PRIV;
      nextPc   = (privBase & ~MASK15) | (ctrl.tlAboveZero ? BIT14 : '0)
               | (typeShift & MASK14);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      errorState  <= 1'b0;
      pathCode    <= PATH_IDLE;
      handlerType <= '0;
      handlerPc   <= '0;
      handlerNpc  <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        errorState  <= ctrl.selError;
        pathCode    <= nextPath;
        handlerType <= effType;
        handlerPc   <= nextPc;
        handlerNpc  <= ctrl.selError ? '0 : nextPc + INSN_BYTES;
      end
    end
  end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_disp_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int TL_W    = $clog2(MAX_TL + 2),
  parameter int TYPE_W  = 9,
  parameter int ADDR_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [TL_W-1:0]   trapLevel,
  input  logic              redBit,
  input  logic              hprivBit,
  input  logic              privBit,
  input  logic [TYPE_W-1:0] trapType,
  input  logic [ADDR_W-1:0] hyperBase,
  input  logic [ADDR_W-1:0] privBase,
  output logic              outValid,
  output logic              errorState,
  output logic [2:0]        pathCode,
  output logic [TYPE_W-1:0] handlerType,
  output logic [ADDR_W-1:0] handlerPc,
  output logic [ADDR_W-1:0] handlerNpc
);
  dispCtrl_t ctrl;

  trap_disp_ctrl #(
    .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TL_W(TL_W), .TYPE_W(TYPE_W)
  ) ctrl_i (
    .reqValid(reqValid), .trapLevel(trapLevel), .redBit(redBit),
    .hprivBit(hprivBit), .privBit(privBit), .trapType(trapType), .ctrl(ctrl)
  );

  trap_disp_datapath #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .trapType(trapType),
    .hyperBase(hyperBase), .privBase(privBase), .outValid(outValid),
    .errorState(errorState), .pathCode(pathCode), .handlerType(handlerType),
    .handlerPc(handlerPc), .handlerNpc(handlerNpc)
  );
endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk #(
  parameter int TL_W   = 3,
  parameter int TYPE_W = 9,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [TL_W-1:0]   trapLevel,
  input logic              redBit,
  input logic              outValid,
  input logic              errorState,
  input logic [2:0]        pathCode,
  input logic [TYPE_W-1:0] handlerType,
  input logic [ADDR_W-1:0] handlerPc,
  input logic [ADDR_W-1:0] handlerNpc
);
  assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(reqValid));

  assert_hold_without_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(handlerPc) && $stable(pathCode) && $stable(handlerType));

  assert_red_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && redBit |=> pathCode == 3'd1 && handlerType == TYPE_W'(5) && !errorState);

  assert_error_no_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && errorState |-> pathCode == 3'd5 && handlerPc == '0 && handlerNpc == '0);

  assert_hyper_offset_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (pathCode == 3'd3 || pathCode == 3'd2) |-> handlerPc[13:5] == 9'(handlerType)
      && handlerPc[4:0] == 5'd0);

  assert_priv_level_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && pathCode == 3'd4 |-> handlerPc[14] == ($past(trapLevel) != '0));

  assert_npc_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !errorState |-> handlerNpc == handlerPc + ADDR_W'(4));
endmodule

bind trap_dispatch trap_dispatch_chk #(.TL_W(TL_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .trapLevel(trapLevel), .redBit(redBit),
  .outValid(outValid), .errorState(errorState), .pathCode(pathCode),
  .handlerType(handlerType), .handlerPc(handlerPc), .handlerNpc(handlerNpc)
);

// File: tb/trap_dispatch_tb.sv
module trap_dispatch_tb_top;
  localparam int MAX_TL  = 6;
  localparam int MAX_PTL = 2;
  localparam int TL_W    = 3;
  localparam int TYPE_W  = 9;
  localparam int ADDR_W  = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [TL_W-1:0]   trapLevel = '0;
  logic              redBit = 1'b0, hprivBit = 1'b0, privBit = 1'b0;
  logic [TYPE_W-1:0] trapType = '0;
  logic [ADDR_W-1:0] hyperBase = '0, privBase = '0;
  logic              outValid, errorState;
  logic [2:0]        pathCode;
  logic [TYPE_W-1:0] handlerType;
  logic [ADDR_W-1:0] handlerPc, handlerNpc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_dispatch #(.MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TL_W(TL_W), .TYPE_W(TYPE_W),
                  .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .trapLevel(trapLevel), .redBit(redBit),
    .hprivBit(hprivBit), .privBit(privBit), .trapType(trapType), .hyperBase(hyperBase),
    .privBase(privBase), .outValid(outValid), .errorState(errorState), .pathCode(pathCode),
    .handlerType(handlerType), .handlerPc(handlerPc), .handlerNpc(handlerNpc)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference result from the requirements
  task automatic refModel(input int tl, input bit r, input bit h, input bit p, input int tt,
                          input logic [ADDR_W-1:0] hb, input logic [ADDR_W-1:0] pb,
                          output int path, output int et, output logic [ADDR_W-1:0] pc,
                          output bit err, output string tag);
    bit tgtHyper;
    tgtHyper = h;  // R2: user and privileged both target privileged
    err = 1'b0;
    if (r || tl == MAX_TL - 1) begin
      path = 1; et = 5; pc = 64'hFFF00000A0; tag = "R3";
    end else if (tl >= MAX_TL) begin
      path = 5; et = tt; pc = '0; err = 1'b1; tag = "R4";
    end else if (tl > MAX_PTL && !tgtHyper) begin
      path = 2; et = 2; tag = "R5";
      pc = (hb & ~64'h3FFF) | 64'h40;
    end else if (tgtHyper || tt >= 384) begin
      path = 3; et = tt; tag = "R6_R7";
      pc = (hb & ~64'h3FFF) | ((64'(tt) << 5) & 64'h3FFF);
    end else begin
      path = 4; et = tt; tag = "R8";
      pc = (pb & ~64'h7FFF) | ((64'(tt) << 5) & 64'h3FFF) | ((tl + 1 > 1) ? 64'h4000 : 64'h0);
    end
    if (p) tag = {tag, "_R2"};
  endtask

  task automatic dispatch(input int tl, input bit r, input bit h, input bit p, input int tt,
                          input logic [ADDR_W-1:0] hb, input logic [ADDR_W-1:0] pb);
    int ePath, eType;
    logic [ADDR_W-1:0] ePc;
    bit eErr;
    string tag;
    refModel(tl, r, h, p, tt, hb, pb, ePath, eType, ePc, eErr, tag);
    @(negedge clk);
    trapLevel = TL_W'(tl); redBit = r; hprivBit = h; privBit = p;
    trapType = TYPE_W'(tt); hyperBase = hb; privBase = pb; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({"R1 valid ", tag}, 64'(outValid), 64'd1);
    check({"path ", tag}, 64'(pathCode), 64'(ePath));
    check({"type ", tag}, 64'(handlerType), 64'(eType));
    check({"pc ", tag}, handlerPc, ePc);
    check({"R4 errorState ", tag}, 64'(errorState), 64'(eErr));
    check({"R9 npc ", tag}, handlerNpc, eErr ? 64'h0 : ePc + 64'd4);
    // R1: no request now, inputs disturbed, result must hold
    trapLevel = ~trapLevel; trapType = ~trapType; hyperBase = ~hyperBase; redBit = ~redBit;
    @(negedge clk);
    check("R1 valid drops", 64'(outValid), 64'd0);
    check("R1 pc holds", handlerPc, ePc);
    check("R1 path holds", 64'(pathCode), 64'(ePath));
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 outValid", 64'(outValid), 64'd0);
    check("R10 path", 64'(pathCode), 64'd0);
    check("R10 pc", handlerPc, 64'd0);
    check("R10 npc", handlerNpc, 64'd0);
    check("R10 errorState", 64'(errorState), 64'd0);
    rstN = 1'b1;

    dispatch(MAX_TL - 1, 0, 0, 1, 100, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321); // R3
    dispatch(MAX_TL, 0, 1, 0, 77, 64'hAAAA_0000_0000_0000, 64'h0);                          // R4
    dispatch(MAX_TL, 1, 1, 0, 77, 64'hAAAA_0000_0000_0000, 64'h0);                          // R3 beats R4
    dispatch(7, 0, 0, 0, 12, 64'h0, 64'h0);                                                  // R4 above max
    dispatch(3, 0, 0, 1, 400, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);                               // R5
    dispatch(4, 0, 0, 0, 9, 64'h0000_0000_0001_C000, 64'h0);                                 // R5 from user
    dispatch(3, 0, 1, 0, 9, 64'h0000_0000_0001_C000, 64'h0);                                 // R2 hyper, not watchdog
    dispatch(0, 0, 0, 1, 383, 64'h5555_5555_5555_5555, 64'h3333_3333_3333_3333);             // R6 383 priv
    dispatch(0, 0, 0, 1, 384, 64'h5555_5555_5555_5555, 64'h3333_3333_3333_3333);             // R6 384 hyper
    dispatch(1, 0, 0, 0, 383, 64'h5555_5555_5555_5555, 64'h3333_3333_3333_3333);             // R8 bit 14
    dispatch(2, 0, 0, 1, 511, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);                               // R6 max type
    dispatch(0, 0, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);                                 // R7

    for (int i = 0; i < 300; i++) begin
      dispatch($urandom_range(0, 7), ($urandom_range(0, 7) == 0), $urandom_range(0, 1),
               $urandom_range(0, 1), $urandom_range(0, 511),
               {$urandom, $urandom}, {$urandom, $urandom});
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule